// File: doc/BRIEF.md
# Counting Semaphore Command Engine

This block holds a bank of 32 counting semaphores of 12 bits each. A sequencer drives it one 32-bit command word at a time. Each word can set, bump or lower a semaphore. It can also hold back until a semaphore reaches a level, or take a unit from a semaphore once that semaphore is positive. Before it executes, a command can additionally wait until no to-device transfers, or no from-device transfers, are still pending. Other agents can change any semaphore through a side port. A combinational peek port reads any semaphore back.

The command input is a valid/ready stream. The engine raises `cmd_ready` in the same cycle in which the presented word can execute, and the word takes effect on the clock edge where `cmd_valid` and `cmd_ready` are both high. A blocked word holds `cmd_ready` low and stalls the stream. The condition is evaluated again every cycle. While `cmd_valid` is high the source must hold `cmd_word` stable. `cmd_ready` is a function of the presented word and may be high while `cmd_valid` is low; it carries no meaning then.

Command fields, by bit position:
- bit 31: enable.
- bit 30: to-device fence.
- bit 29: from-device fence.
- bits 26:24: opcode.
- bit 22: sync tag (1 means presync, 0 means postsync).
- bits 20:16: semaphore index.
- bits 11:0: operand.
- bits 28:27, 23, 21 and 15:12: unused.

Top module: `sem_cmd_engine`

## Requirements
- R1: After reset every semaphore reads 0 and `done`, `err` and `done_presync` are low.
- R2: A word with bit 31 clear is accepted in the cycle it is presented, whatever its fences and the pending counts, and it changes no semaphore.
- R3: An enabled word with bit 30 set keeps `cmd_ready` low while `todev_pending` is nonzero. An enabled word with bit 29 set does the same while `fromdev_pending` is nonzero. Each fence ignores the other counter.
- R4: Opcode 1 writes the operand into the indexed semaphore.
- R5: Opcode 2 adds one and saturates at 4095. Opcode 3 subtracts one and saturates at 0.
- R6: Opcode 4 is accepted only when the semaphore equals the operand, and it leaves the semaphore unchanged.
- R7: Opcode 5 is accepted only when the semaphore is greater than or equal to the operand, and it leaves the semaphore unchanged.
- R8: Opcode 6 is accepted only when the semaphore is nonzero, and it then subtracts one. A side-port update to the same semaphore in the acceptance cycle is applied first, and both the test and the decrement see the updated value.
- R9: Opcode 7 is accepted once its fences clear, changes nothing, and raises `err` together with `done`.
- R10: `done` is high for exactly the one cycle after each accepted word. `done_presync` in that cycle equals bit 22 of that word.
- R11: When `side_valid` is high, `side_op` acts on semaphore `side_idx` at the clock edge: 0 loads `side_value`, 1 adds one saturating at 4095, 2 subtracts one saturating at 0, and 3 has no effect.
- R12: `rd_value` shows the stored value of semaphore `rd_idx` combinationally.
- R13: Opcode 0 changes nothing. Bits 28:27, 23, 21 and 15:12 have no effect on any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word presented |
| cmd_ready | output | 1 | Presented word can execute this cycle |
| cmd_word | input | 32 | Command word |
| todev_pending | input | CNT_W | Outstanding to-device transfers |
| fromdev_pending | input | CNT_W | Outstanding from-device transfers |
| side_valid | input | 1 | Side-port update strobe |
| side_op | input | 2 | Side operation: 0 load, 1 add one, 2 subtract one, 3 none |
| side_idx | input | 5 | Side-port semaphore index |
| side_value | input | 12 | Side-port load value |
| rd_idx | input | 5 | Peek index |
| rd_value | output | 12 | Peeked semaphore value |
| done | output | 1 | One-cycle completion pulse |
| done_presync | output | 1 | Sync tag of the completed word |
| err | output | 1 | Completed word used the reserved opcode |

## Verification
The bench builds the block with `CNT_W` set to 4. This keeps the pending counters narrow, while the nonzero counts 2, 3 and 5 still show that any nonzero count holds a fence closed. Index 31 and operand 4095 sit at the edges of the fixed field widths, so saturation at the top and at zero are both reached. The stall cases use the side port to release blocked waits and a blocked take in the very cycle of the side update, which exercises the rule that the side update is applied first.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int CMD_W   = 32;
  localparam int VAL_W   = 12;
  localparam int IDX_W   = 5;
  localparam int NUM_SEM = 1 << IDX_W;

  // bit positions the decoder relies on
  localparam int B_EN    = 31;
  localparam int B_FTO   = 30;
  localparam int B_FFROM = 29;
  localparam int B_OPLO  = 24;
  localparam int B_PRE   = 22;
  localparam int B_IDXLO = 16;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_INIT = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_WEQ  = 3'd4,
    OP_WGE  = 3'd5,
    OP_TAKE = 3'd6,
    OP_RSV  = 3'd7
  } sem_op_e;

  typedef enum logic [1:0] {
    SIDE_LOAD = 2'd0,
    SIDE_UP   = 2'd1,
    SIDE_DOWN = 2'd2,
    SIDE_NONE = 2'd3
  } side_op_e;

  typedef struct packed {
    logic             en;
    logic             fence_to;
    logic             fence_from;
    sem_op_e          op;
    logic             pre;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
  } sem_cmd_t;

  function automatic logic [VAL_W-1:0] sat_up(logic [VAL_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [VAL_W-1:0] sat_down(logic [VAL_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [VAL_W-1:0] side_apply(side_op_e op, logic [VAL_W-1:0] cur,
                                                  logic [VAL_W-1:0] ld);
    case (op)
      SIDE_LOAD: return ld;
      SIDE_UP:   return sat_up(cur);
      SIDE_DOWN: return sat_down(cur);
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/sem_cmd_decode.sv
module sem_cmd_decode
  import sem_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output sem_cmd_t         cmd
);
  always_comb begin
    cmd.en         = word[B_EN];
    cmd.fence_to   = word[B_FTO];
    cmd.fence_from = word[B_FFROM];
    cmd.op         = sem_op_e'(word[B_OPLO +: 3]);
    cmd.pre        = word[B_PRE];
    cmd.idx        = word[B_IDXLO +: IDX_W];
    cmd.val        = word[VAL_W-1:0];
  end
endmodule

// File: rtl/sem_cmd_exec.sv
module sem_cmd_exec
  import sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  sem_cmd_t         cmd,
  input  logic [VAL_W-1:0] eff_val,
  input  logic [CNT_W-1:0] todev_pending,
  input  logic [CNT_W-1:0] fromdev_pending,
  output logic             go,
  output logic             wr,
  output logic [VAL_W-1:0] wr_val,
  output logic             bad_op
);
  logic fences_clear;
  logic cond_ok;

  always_comb begin
    fences_clear = !(cmd.fence_to   && (todev_pending   != '0)) &&
                   !(cmd.fence_from && (fromdev_pending != '0));
    cond_ok = 1'b1;
    wr      = 1'b0;
    wr_val  = eff_val;
    case (cmd.op)
      OP_INIT: begin wr = 1'b1; wr_val = cmd.val;           end
      OP_INC:  begin wr = 1'b1; wr_val = sat_up(eff_val);   end
      OP_DEC:  begin wr = 1'b1; wr_val = sat_down(eff_val); end
      OP_WEQ:  cond_ok = (eff_val == cmd.val);
      OP_WGE:  cond_ok = (eff_val >= cmd.val);
      OP_TAKE: begin
        cond_ok = (eff_val != '0);
        wr      = 1'b1;
        wr_val  = eff_val - 1'b1;
      end
      default: ;
    endcase
    go     = !cmd.en || (fences_clear && cond_ok);
    wr     = wr && cmd.en;
    bad_op = cmd.en && (cmd.op == OP_RSV);
  end
endmodule

// File: rtl/sem_store.sv
module sem_store
  import sem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             side_valid,
  input  side_op_e         side_op,
  input  logic [IDX_W-1:0] side_idx,
  input  logic [VAL_W-1:0] side_value,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [VAL_W-1:0] eng_val,
  input  logic [IDX_W-1:0] look_idx,
  output logic [VAL_W-1:0] eff_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VAL_W-1:0] rd_value
);
  logic [VAL_W-1:0] q [NUM_SEM];

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    logic [VAL_W-1:0] d;
    always_comb begin
      d = q[i];
      if (side_valid && side_idx == IDX_W'(i)) d = side_apply(side_op, q[i], side_value);
      if (eng_we && eng_idx == IDX_W'(i))      d = eng_val;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= d;
    end
  end

  // side update forwarded ahead of the engine's test and write
  always_comb begin
    eff_val = q[look_idx];
    if (side_valid && side_idx == look_idx)
      eff_val = side_apply(side_op, q[look_idx], side_value);
  end

  assign rd_value = q[rd_idx];
endmodule

// File: rtl/sem_cmd_engine.sv
module sem_cmd_engine
  import sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic [CNT_W-1:0] todev_pending,
  input  logic [CNT_W-1:0] fromdev_pending,
  input  logic             side_valid,
  input  logic [1:0]       side_op,
  input  logic [IDX_W-1:0] side_idx,
  input  logic [VAL_W-1:0] side_value,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VAL_W-1:0] rd_value,
  output logic             done,
  output logic             done_presync,
  output logic             err
);
  sem_cmd_t         cmd;
  logic [VAL_W-1:0] eff_val;
  logic             go, wr, bad_op, fire;
  logic [VAL_W-1:0] wr_val;

  sem_cmd_decode u_dec (.word(cmd_word), .cmd(cmd));

  sem_cmd_exec #(.CNT_W(CNT_W)) u_exec (
    .cmd(cmd), .eff_val(eff_val),
    .todev_pending(todev_pending), .fromdev_pending(fromdev_pending),
    .go(go), .wr(wr), .wr_val(wr_val), .bad_op(bad_op)
  );

  assign cmd_ready = go;
  assign fire      = cmd_valid && go;

  sem_store u_store (
    .clk(clk), .rst_n(rst_n),
    .side_valid(side_valid), .side_op(side_op_e'(side_op)),
    .side_idx(side_idx), .side_value(side_value),
    .eng_we(fire && wr), .eng_idx(cmd.idx), .eng_val(wr_val),
    .look_idx(cmd.idx), .eff_val(eff_val),
    .rd_idx(rd_idx), .rd_value(rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= 1'b0;
      done_presync <= 1'b0;
      err          <= 1'b0;
    end else begin
      done         <= fire;
      done_presync <= fire && cmd.pre;
      err          <= fire && bad_op;
    end
  end
endmodule

// File: rtl/sem_cmd_engine_chk.sv
module sem_cmd_engine_chk
  import sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [CMD_W-1:0] cmd_word,
  input logic [CNT_W-1:0] todev_pending,
  input logic [CNT_W-1:0] fromdev_pending,
  input logic             side_valid,
  input logic [IDX_W-1:0] rd_idx,
  input logic [VAL_W-1:0] rd_value,
  input logic             done,
  input logic             err
);
  logic en;
  logic [2:0] op;
  logic [IDX_W-1:0] idx;
  assign en  = cmd_word[B_EN];
  assign op  = cmd_word[B_OPLO +: 3];
  assign idx = cmd_word[B_IDXLO +: IDX_W];

  p_disabled_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !en) |-> cmd_ready);

  p_fence_to_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && en && cmd_word[B_FTO] && todev_pending != '0) |-> !cmd_ready);

  p_fence_from_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && en && cmd_word[B_FFROM] && fromdev_pending != '0) |-> !cmd_ready);

  p_weq_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && en && op == 3'd4 && !side_valid && rd_idx == idx &&
     rd_value != cmd_word[VAL_W-1:0]) |-> !cmd_ready);

  p_take_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && en && op == 3'd6 && !side_valid && rd_idx == idx &&
     rd_value == '0) |-> !cmd_ready);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> done);

  p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !done);

  p_quiet_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!side_valid && !(cmd_valid && cmd_ready)) |=> (!$stable(rd_idx) || $stable(rd_value)));
endmodule

bind sem_cmd_engine sem_cmd_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_word(cmd_word), .todev_pending(todev_pending), .fromdev_pending(fromdev_pending),
  .side_valid(side_valid), .rd_idx(rd_idx), .rd_value(rd_value),
  .done(done), .err(err)
);

// File: tb/sem_cmd_engine_bench.sv
module sem_cmd_engine_bench;
  localparam int CNT_W = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_word;
  logic [CNT_W-1:0] todev_pending, fromdev_pending;
  logic        side_valid;
  logic [1:0]  side_op;
  logic [4:0]  side_idx;
  logic [11:0] side_value;
  logic [4:0]  rd_idx;
  logic [11:0] rd_value;
  logic        done, done_presync, err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sem_cmd_engine #(.CNT_W(CNT_W)) u_sem_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .todev_pending(todev_pending), .fromdev_pending(fromdev_pending),
    .side_valid(side_valid), .side_op(side_op), .side_idx(side_idx),
    .side_value(side_value), .rd_idx(rd_idx), .rd_value(rd_value),
    .done(done), .done_presync(done_presync), .err(err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // {command word, expected value at its index afterwards, expected err}
  localparam int NV = 14;
  localparam logic [44:0] VEC [NV] = '{
    {32'h8103_0064, 12'd100,  1'b0},  // R4 load idx3
    {32'h8203_0000, 12'd101,  1'b0},  // R5 add one
    {32'h8303_0000, 12'd100,  1'b0},  // R5 subtract one
    {32'h8403_0064, 12'd100,  1'b0},  // R6 equal already met
    {32'h8503_0032, 12'd100,  1'b0},  // R7 at-least already met
    {32'h8603_0000, 12'd99,   1'b0},  // R8 take from positive
    {32'h0103_0007, 12'd99,   1'b0},  // R2 disabled load ignored
    {32'h98A3_F123, 12'd99,   1'b0},  // R13 no-op with unused bits set
    {32'h8703_0005, 12'd99,   1'b1},  // R9 reserved opcode
    {32'h811F_0FFF, 12'd4095, 1'b0},  // R4 top index, top value
    {32'h821F_0000, 12'd4095, 1'b0},  // R5 saturate high
    {32'h8300_0000, 12'd0,    1'b0},  // R5 saturate low
    {32'h81A5_F0AB, 12'd171,  1'b0},  // R13 load with unused bits set
    {32'h8145_000A, 12'd10,   1'b0}   // R10 presync tag
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0;
    todev_pending = '0; fromdev_pending = '0;
    side_valid = 1'b0; side_op = 2'd3; side_idx = '0; side_value = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 presync", done_presync, 0);
    rd_idx = 5'd3;  #1 check("R1 idx3", rd_value, 0);
    rd_idx = 5'd31; #1 check("R1 idx31", rd_value, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      w = VEC[i][44:13];
      @(negedge clk);
      cmd_word = w; cmd_valid = 1'b1; rd_idx = w[20:16];
      #1 check($sformatf("R2 ready vec%0d", i), cmd_ready, 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      check($sformatf("R10 done vec%0d", i), done, 1);
      check($sformatf("R9 err vec%0d", i), err, VEC[i][0]);
      check($sformatf("R10 presync vec%0d", i), done_presync, w[22]);
      check($sformatf("R12 value vec%0d", i), rd_value, VEC[i][12:1]);
    end
    @(negedge clk);
    check("R10 single pulse", done, 0);

    // R3 to-device fence
    todev_pending = 4'd3;
    cmd_word = 32'hC103_0011; cmd_valid = 1'b1; rd_idx = 5'd3;
    #1 check("R3 to fence blocks", cmd_ready, 0);
    @(negedge clk);
    check("R3 no change while fenced", rd_value, 99);
    check("R3 no done while fenced", done, 0);
    todev_pending = '0;
    #1 check("R3 to fence opens", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R3 done", done, 1);
    check("R3 value", rd_value, 17);

    // R3 from-device fence, ignores to-device count
    todev_pending = 4'd5; fromdev_pending = 4'd2;
    cmd_word = 32'hA103_0022; cmd_valid = 1'b1;
    #1 check("R3 from fence blocks", cmd_ready, 0);
    @(negedge clk);
    fromdev_pending = '0;
    #1 check("R3 from fence ignores to count", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0; todev_pending = '0;
    check("R3 from value", rd_value, 34);

    // R2 disabled word bypasses an active fence
    todev_pending = 4'd3;
    cmd_word = 32'h4103_0001; cmd_valid = 1'b1;
    #1 check("R2 disabled ignores fence", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0; todev_pending = '0;
    check("R2 disabled no change", rd_value, 34);

    // R6 and R11: equal-wait released by side increments
    cmd_word = 32'h8407_0002; cmd_valid = 1'b1; rd_idx = 5'd7;
    #1 check("R6 stalls", cmd_ready, 0);
    @(negedge clk);
    side_valid = 1'b1; side_op = 2'd1; side_idx = 5'd7;
    #1 check("R6 still stalls at 1", cmd_ready, 0);
    @(negedge clk);
    check("R11 side add one", rd_value, 1);
    #1 check("R6 released at 2", cmd_ready, 1);
    @(negedge clk);
    side_valid = 1'b0; cmd_valid = 1'b0;
    check("R6 done", done, 1);
    check("R6 value kept", rd_value, 2);

    // R8: take on zero, released by a same-cycle side increment
    cmd_word = 32'h8609_0000; cmd_valid = 1'b1; rd_idx = 5'd9;
    #1 check("R8 zero stalls", cmd_ready, 0);
    @(negedge clk);
    check("R8 no done", done, 0);
    side_valid = 1'b1; side_op = 2'd1; side_idx = 5'd9;
    #1 check("R8 same-cycle side seen", cmd_ready, 1);
    @(negedge clk);
    side_valid = 1'b0; cmd_valid = 1'b0;
    check("R8 done", done, 1);
    check("R8 side then take", rd_value, 0);

    // R7: at-least wait released by a side load
    cmd_word = 32'h810A_0005; cmd_valid = 1'b1; rd_idx = 5'd10;
    @(negedge clk);
    cmd_word = 32'h850A_0006;
    #1 check("R7 stalls below", cmd_ready, 0);
    @(negedge clk);
    side_valid = 1'b1; side_op = 2'd0; side_idx = 5'd10; side_value = 12'd9;
    #1 check("R7 released", cmd_ready, 1);
    @(negedge clk);
    side_valid = 1'b0; cmd_valid = 1'b0;
    check("R7 value kept", rd_value, 9);

    // R11: side saturation and no-op code
    rd_idx = 5'd11;
    side_valid = 1'b1; side_op = 2'd2; side_idx = 5'd11;
    @(negedge clk);
    check("R11 side floor", rd_value, 0);
    side_op = 2'd0; side_value = 12'd4095;
    @(negedge clk);
    side_op = 2'd1;
    @(negedge clk);
    check("R11 side ceiling", rd_value, 4095);
    side_op = 2'd3; side_value = 12'd5;
    @(negedge clk);
    side_valid = 1'b0;
    check("R11 code 3 no effect", rd_value, 4095);
    check("R10 no done from side", done, 0);

    finish_run();
  end
endmodule